// File: doc/BRIEF.md
# Quarter-Duty Half-Bias LCD Scan Driver

This block drives a multiplexed liquid-crystal panel with four backplanes (commons) and up to 28 segment pins at 1/4 duty and 1/2 bias. It runs from a 75 kHz clock and gives a 75 Hz frame. Every common and segment pin comes out as a 2-bit drive-level code. External analog switches or a resistor ladder turn each code into GND, the half level or VDD. Each common slot is split into two halves of opposite polarity, so no pixel sees a DC component over a frame.

The pixel pattern is held per segment pin as a "digit", with one bit for each common. A digit can be written directly. It can also be written through a staging latch, which updates the digit one clock later. The upper segment pins can each be released to general-purpose I/O. A released pin stops driving and tells the pad logic through its enable output. While the block is in reset or in backup, every common and segment output is held at GND. When backup ends, the scan restarts from the first common.

Top module: `lcd_quad_driver`

## Requirements
- R1: Level codes are 2'b00 = GND, 2'b01 = half level and 2'b10 = VDD. While rst_ni is low, every com_o and seg_o pair reads 2'b00 and every pixel bit is cleared. After reset all pixels read as off.
- R2: From the first rising edge with backup_i high, every com_o and seg_o pair reads 2'b00. One edge after backup_i returns low, the scan restarts with common 0 in its positive half.
- R3: Each common is selected for two halves of CLK_HZ/(FRAME_HZ*8) cycles each (125 by default). In the first half the selected common is 2'b10 (VDD) and in the second half it is 2'b00 (GND). Commons are selected in the order 0,1,2,3, which gives a frame of 1000 cycles.
- R4: While the display is active, every common that is not selected is 2'b01 and exactly one common is at a full level.
- R5: A driven segment whose pixel bit is 1 for the selected common takes the full level opposite to that common. When the bit is 0, it takes the same level as that common.
- R6: A direct write (wr_en_i=1, wr_via_latch_i=0) stores wr_data_i into digit wr_digit_i at the clock edge. Bit c of a digit is the pixel of that segment pin under common c.
- R7: A staged write (wr_en_i=1, wr_via_latch_i=1) loads the staging latch at the edge, and the latch is copied into the digit at the next edge.
- R8: If a direct write targets the same digit in the cycle in which a staged write is committing, the direct data is kept.
- R9: A write to a digit index of NUM_SEG or above changes no pixel.
- R10: gpio_sel_i bit k releases segment pin FIXED_SEG+k (pin 12+k by default). A released pin has seg_en_o low and seg_o 2'b00. Its stored pattern is kept and shows again when the pin is reclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 75 kHz scan clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| backup_i | input | 1 | Backup mode, blanks all outputs to GND |
| wr_en_i | input | 1 | Digit write strobe |
| wr_via_latch_i | input | 1 | 1: route the write through the staging latch |
| wr_digit_i | input | 5 | Target digit (segment pin index) |
| wr_data_i | input | 4 | Pixel bits, bit c for common c |
| gpio_sel_i | input | 16 | Per-pin release of upper segment pins |
| com_o | output | 8 | Level codes of commons, pair c at bits 2c+1:2c |
| seg_o | output | 56 | Level codes of segments, pair s at bits 2s+1:2s |
| seg_en_o | output | 28 | 1 when the pin is driven as a segment |

## Verification
The hardest case to reach is a staged write that commits in the same cycle as a direct write to the same digit. The stimulus table places a staged write and a direct write to one digit on consecutive cycles, which forces that collision. The result is only visible by waiting for each common's slot and reading the segment pair in both halves. So the bench synchronises on the common outputs themselves, samples every pin in all eight half-slots and compares against its own pixel model. Backup entry and exit partway through a slot are used to check the restart point.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  typedef enum logic [1:0] {
    LVL_GND  = 2'b00,
    LVL_HALF = 2'b01,
    LVL_VDD  = 2'b10
  } lvl_e;
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int HALF_CYCLES = 125,
  parameter int NUM_COM     = 4,
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1,
  localparam int CW    = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blank_i,
  output logic [CW-1:0] com_sel_o,
  output logic          phase_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last_w;

  assign last_w = (cnt_q == CNT_W'(HALF_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      phase_o   <= 1'b0;
      com_sel_o <= '0;
    end else if (blank_i) begin
      cnt_q     <= '0;
      phase_o   <= 1'b0;
      com_sel_o <= '0;
    end else if (last_w) begin
      cnt_q <= '0;
      if (phase_o) begin
        phase_o   <= 1'b0;
        com_sel_o <= (com_sel_o == CW'(NUM_COM - 1)) ? '0 : com_sel_o + 1'b1;
      end else begin
        phase_o <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < HALF_CYCLES);

  // R3
  phase_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_i && last_w) |=> (phase_o != $past(phase_o)));

  // R3
  com_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_i && !(last_w && phase_o)) |=> $stable(com_sel_o));
endmodule

// File: rtl/lcd_pattern_mem.sv
module lcd_pattern_mem #(
  parameter int NUM_SEG = 28,
  parameter int NUM_COM = 4,
  localparam int DIG_W  = $clog2(NUM_SEG)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic                             wr_via_latch_i,
  input  logic [DIG_W-1:0]                 wr_digit_i,
  input  logic [NUM_COM-1:0]               wr_data_i,
  output logic [NUM_SEG-1:0][NUM_COM-1:0]  pix_o
);
  logic               in_range_w, direct_w, stage_w;
  logic [NUM_COM-1:0] latch_q;
  logic [DIG_W-1:0]   pend_dig_q;
  logic               pend_q;

  assign in_range_w = (32'(wr_digit_i) < 32'(NUM_SEG));
  assign direct_w   = wr_en_i && !wr_via_latch_i && in_range_w;
  assign stage_w    = wr_en_i &&  wr_via_latch_i && in_range_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q    <= '0;
      pend_dig_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      pend_q <= stage_w;
      if (stage_w) begin
        latch_q    <= wr_data_i;
        pend_dig_q <= wr_digit_i;
      end
    end
  end

  for (genvar d = 0; d < NUM_SEG; d++) begin : g_dig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        pix_o[d] <= '0;
      else if (direct_w && wr_digit_i == DIG_W'(d))
        pix_o[d] <= wr_data_i;  // direct path has priority
      else if (pend_q && pend_dig_q == DIG_W'(d))
        pix_o[d] <= latch_q;
    end
  end

  // R6
  direct_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_w |=> (pix_o[$past(wr_digit_i)] == $past(wr_data_i)));

  // R7
  stage_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !(direct_w && wr_digit_i == pend_dig_q))
      |=> (pix_o[$past(pend_dig_q)] == $past(latch_q)));

  // R7
  stage_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_w |=> pend_q);
endmodule

// File: rtl/lcd_level_mux.sv
module lcd_level_mux
  import lcd_drv_pkg::*;
#(
  parameter int NUM_SEG   = 28,
  parameter int NUM_COM   = 4,
  parameter int FIXED_SEG = 12,
  localparam int NUM_GPIO = NUM_SEG - FIXED_SEG,
  localparam int CW       = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                            blank_i,
  input  logic [CW-1:0]                   com_sel_i,
  input  logic                            phase_i,
  input  logic [NUM_SEG-1:0][NUM_COM-1:0] pix_i,
  input  logic [NUM_GPIO-1:0]             gpio_sel_i,
  output logic [2*NUM_COM-1:0]            com_o,
  output logic [2*NUM_SEG-1:0]            seg_o,
  output logic [NUM_SEG-1:0]              seg_en_o
);
  lvl_e full_w, anti_w;

  // first half: selected common high, second half: low
  assign full_w = phase_i ? LVL_GND : LVL_VDD;
  assign anti_w = phase_i ? LVL_VDD : LVL_GND;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    always_comb begin
      if (blank_i)                    com_o[2*c +: 2] = LVL_GND;
      else if (com_sel_i == CW'(c))   com_o[2*c +: 2] = full_w;
      else                            com_o[2*c +: 2] = LVL_HALF;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    if (s < FIXED_SEG) begin : g_fixed
      assign seg_en_o[s] = 1'b1;
    end else begin : g_shared
      assign seg_en_o[s] = !gpio_sel_i[s - FIXED_SEG];
    end

    always_comb begin
      if (blank_i || !seg_en_o[s])  seg_o[2*s +: 2] = LVL_GND;
      else if (pix_i[s][com_sel_i]) seg_o[2*s +: 2] = anti_w;
      else                          seg_o[2*s +: 2] = full_w;
    end
  end
endmodule

// File: rtl/lcd_quad_driver.sv
module lcd_quad_driver
  import lcd_drv_pkg::*;
#(
  parameter int CLK_HZ    = 75000,
  parameter int FRAME_HZ  = 75,
  parameter int NUM_COM   = 4,
  parameter int NUM_SEG   = 28,
  parameter int FIXED_SEG = 12,
  localparam int HALF_CYCLES = CLK_HZ / (FRAME_HZ * NUM_COM * 2),
  localparam int DIG_W       = $clog2(NUM_SEG),
  localparam int NUM_GPIO    = NUM_SEG - FIXED_SEG,
  localparam int CW          = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   backup_i,
  input  logic                   wr_en_i,
  input  logic                   wr_via_latch_i,
  input  logic [DIG_W-1:0]       wr_digit_i,
  input  logic [NUM_COM-1:0]     wr_data_i,
  input  logic [NUM_GPIO-1:0]    gpio_sel_i,
  output logic [2*NUM_COM-1:0]   com_o,
  output logic [2*NUM_SEG-1:0]   seg_o,
  output logic [NUM_SEG-1:0]     seg_en_o
);
  logic                            blank_q;
  logic [CW-1:0]                   com_sel_w;
  logic                            phase_w;
  logic [NUM_SEG-1:0][NUM_COM-1:0] pix_w;

  // blank is held from reset until the first edge with backup low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blank_q <= 1'b1;
    else         blank_q <= backup_i;
  end

  lcd_scan_timer #(
    .HALF_CYCLES (HALF_CYCLES),
    .NUM_COM     (NUM_COM)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .blank_i   (blank_q),
    .com_sel_o (com_sel_w),
    .phase_o   (phase_w)
  );

  lcd_pattern_mem #(
    .NUM_SEG (NUM_SEG),
    .NUM_COM (NUM_COM)
  ) u_mem (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_via_latch_i (wr_via_latch_i),
    .wr_digit_i     (wr_digit_i),
    .wr_data_i      (wr_data_i),
    .pix_o          (pix_w)
  );

  lcd_level_mux #(
    .NUM_SEG   (NUM_SEG),
    .NUM_COM   (NUM_COM),
    .FIXED_SEG (FIXED_SEG)
  ) u_mux (
    .blank_i    (blank_q),
    .com_sel_i  (com_sel_w),
    .phase_i    (phase_w),
    .pix_i      (pix_w),
    .gpio_sel_i (gpio_sel_i),
    .com_o      (com_o),
    .seg_o      (seg_o),
    .seg_en_o   (seg_en_o)
  );

  logic [NUM_COM-1:0] com_full_w;
  for (genvar c = 0; c < NUM_COM; c++) begin : g_full
    assign com_full_w[c] = (com_o[2*c +: 2] != LVL_HALF);
  end

  // R1
  blank_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_q |-> (com_o == '0 && seg_o == '0));

  // R2
  backup_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_i |=> (com_o == '0 && seg_o == '0));

  // R4
  one_com_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_q |-> ($countones(com_full_w) == 1));

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg_chk
    // R10
    gpio_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seg_en_o[s] |-> (seg_o[2*s +: 2] == LVL_GND));
    // R1
    seg_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seg_o[2*s +: 2] != 2'b11 && seg_o[2*s +: 2] != LVL_HALF);
  end
endmodule

// File: tb/lcd_quad_driver_tb.sv
module lcd_quad_driver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 28;
  localparam int NCOM = 4;
  localparam int FIX  = 12;
  localparam int HALF = 125;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        backup = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_via = 1'b0;
  logic [4:0]  wr_dig = '0;
  logic [3:0]  wr_dat = '0;
  logic [15:0] gpio = '0;
  logic [7:0]  com_o;
  logic [55:0] seg_o;
  logic [27:0] seg_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [3:0] mdl [NSEG];

  // {via, digit, data}; last two hit the same digit back to back (R8)
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 5'd0,  4'h1},
    {1'b0, 5'd1,  4'h2},
    {1'b1, 5'd5,  4'hC},
    {1'b0, 5'd11, 4'hF},
    {1'b1, 5'd12, 4'h9},
    {1'b0, 5'd20, 4'h6},
    {1'b1, 5'd27, 4'hA},
    {1'b0, 5'd27, 4'h5}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_quad_driver u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .backup_i       (backup),
    .wr_en_i        (wr_en),
    .wr_via_latch_i (wr_via),
    .wr_digit_i     (wr_dig),
    .wr_data_i      (wr_dat),
    .gpio_sel_i     (gpio),
    .com_o          (com_o),
    .seg_o          (seg_o),
    .seg_en_o       (seg_en_o)
  );

  task automatic check(input bit ok, input string tag, input logic [55:0] act,
                       input logic [55:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_com(int c, int ph);
    logic [7:0] v;
    for (int k = 0; k < NCOM; k++)
      v[2*k +: 2] = (k == c) ? (ph == 0 ? 2'b10 : 2'b00) : 2'b01;
    return v;
  endfunction

  function automatic logic [27:0] exp_en();
    logic [27:0] v;
    for (int s = 0; s < NSEG; s++) v[s] = (s < FIX) ? 1'b1 : !gpio[s-FIX];
    return v;
  endfunction

  function automatic logic [55:0] exp_seg(int c, int ph);
    logic [55:0] v;
    logic [27:0] en;
    en = exp_en();
    for (int s = 0; s < NSEG; s++) begin
      if (!en[s])           v[2*s +: 2] = 2'b00;
      else if (mdl[s][c])   v[2*s +: 2] = (ph == 0) ? 2'b00 : 2'b10;
      else                  v[2*s +: 2] = (ph == 0) ? 2'b10 : 2'b00;
    end
    return v;
  endfunction

  task automatic write(input logic via, input logic [4:0] dig, input logic [3:0] dat);
    wr_en = 1'b1; wr_via = via; wr_dig = dig; wr_dat = dat;
    if (32'(dig) < NSEG) mdl[dig] = dat;
    @(negedge clk);
  endtask

  task automatic wr_idle();
    wr_en = 1'b0; wr_via = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  // synchronise on each common's half-slot and compare every pin
  task automatic scan_check(input string tag);
    for (int c = 0; c < NCOM; c++) begin
      for (int ph = 0; ph < 2; ph++) begin
        logic [1:0] want;
        int n;
        want = (ph == 0) ? 2'b10 : 2'b00;
        n = 0;
        while (com_o[2*c +: 2] != want && n < 2000) begin
          @(negedge clk); n++;
        end
        check(n < 2000, {tag, " R3 slot reached"}, 56'(n), 56'd0);
        check(com_o == exp_com(c, ph), {tag, " R4 commons"}, 56'(com_o), 56'(exp_com(c, ph)));
        check(seg_o == exp_seg(c, ph), {tag, " R5 segments"}, seg_o, exp_seg(c, ph));
        check(seg_en_o == exp_en(), {tag, " R10 enables"}, 56'(seg_en_o), 56'(exp_en()));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    for (int s = 0; s < NSEG; s++) mdl[s] = '0;
    repeat (3) @(negedge clk);
    // R1 held in reset
    check(com_o == '0 && seg_o == '0, "R1 outputs low in reset", seg_o, '0);

    rst_ni = 1'b1;
    check(com_o == '0 && seg_o == '0, "R1 still blank before first edge", 56'(com_o), '0);
    @(negedge clk);
    check(com_o == exp_com(0, 0), "R3 com0 high after reset", 56'(com_o), 56'(exp_com(0, 0)));
    check(seg_o == exp_seg(0, 0), "R1 all pixels off after reset", seg_o, exp_seg(0, 0));

    // R3 half-slot lengths
    n = 1;
    forever begin @(negedge clk); if (com_o[1:0] == 2'b10) n++; else break; end
    check(n == HALF, "R3 positive half length", 56'(n), 56'(HALF));
    check(com_o == exp_com(0, 1), "R3 com0 low half", 56'(com_o), 56'(exp_com(0, 1)));
    n = 1;
    forever begin @(negedge clk); if (com_o[1:0] == 2'b00) n++; else break; end
    check(n == HALF, "R3 negative half length", 56'(n), 56'(HALF));
    check(com_o == exp_com(1, 0), "R3 com1 follows com0", 56'(com_o), 56'(exp_com(1, 0)));

    // R6 R7 R8 vector table
    for (int i = 0; i < 8; i++) write(VEC[i][9], VEC[i][8:4], VEC[i][3:0]);
    wr_idle();
    scan_check("R6_R7_R8 table");

    // R9 out-of-range digit
    write(1'b0, 5'd30, 4'hF);
    write(1'b1, 5'd31, 4'hF);
    wr_idle();
    scan_check("R9 ignored index");

    // R8 again with a different digit pair order, R7 alone
    write(1'b1, 5'd3, 4'h7);
    write(1'b0, 5'd3, 4'h8);
    write(1'b1, 5'd4, 4'hE);
    wr_idle();
    scan_check("R7_R8 collision");

    // R10 release pins 12 and 27, then reclaim
    gpio = 16'h8001;
    @(negedge clk);
    scan_check("R10 released");
    gpio = '0;
    @(negedge clk);
    scan_check("R10 reclaimed");

    // R2 backup mid-slot
    repeat (37) @(negedge clk);
    backup = 1'b1;
    @(negedge clk);
    check(com_o == '0 && seg_o == '0, "R2 blank in backup", seg_o, '0);
    repeat (20) @(negedge clk);
    check(com_o == '0 && seg_o == '0, "R2 stays blank", 56'(com_o), '0);
    backup = 1'b0;
    @(negedge clk);
    check(com_o == exp_com(0, 0), "R2 restart at com0", 56'(com_o), 56'(exp_com(0, 0)));
    check(seg_o == exp_seg(0, 0), "R2 pattern kept over backup", seg_o, exp_seg(0, 0));

    // R1 reset mid-run clears pattern
    repeat (50) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(com_o == '0 && seg_o == '0, "R1 async blank", seg_o, '0);
    for (int s = 0; s < NSEG; s++) mdl[s] = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    scan_check("R1 cleared after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule